// File: doc/BRIEF.md
# Memory Test Address Sequencer

This block produces the sequence of row, column and bank addresses that a DRAM self-test engine walks. Software fixes a start and an end value for each of the three fields, chooses one of four traversal orders, a counting direction and whether alternate addresses are complemented, and then pulses a start strobe. The sequencer presents one address at a time with a valid strobe. The command engine takes each address by raising a ready signal, which moves the sequencer on to the next address. The last address of the pass carries a done flag.

Each field behaves as a counter that runs from its start value to its end value and then returns to its start value. The counters are chained, and the chaining order sets the traversal order. Field widths can be set below the maximum widths. Counting then wraps modulo the programmed width, and the complemented addresses stay inside that width. The column field is presented on a set of address lines with one gap, so that the line used for other purposes by the DRAM command encoding never carries a column bit.

Top module: `mt_addr_seq`

## Requirements
- R1: After reset, and at any time reset is held, `valid_o` and `done_o` are 0.
- R2: All configuration inputs are sampled in the cycle that `start_i` is high, and a start pulse during a run restarts the pass. In the cycle after that edge, `valid_o` is 1 and the outputs show the start values of all three fields, masked to the programmed widths and never complemented.
- R3: Order code 0 (fast-X): the row advances on every accepted address; the column advances when the row wraps; the bank advances when the row and the column wrap together.
- R4: Order code 1 (fast-Y): the column advances on every accepted address; the row advances when the column wraps; the bank advances when both wrap.
- R5: Order code 3 (XZY): the row advances on every accepted address; the bank advances when the row wraps; the column advances when the row and the bank wrap together.
- R6: Order code 2 (fast-XY): the row and the column step together. When either of them has just been at its end value, both return to their start values and the bank advances. The pass ends on the address where the bank is at its end value and the row or the column is at its end value.
- R7: With `down_i`=1 every field steps by -1 instead of +1, from its start value toward its end value.
- R8: With `dai_i`=1 the 2nd, 4th, 6th and later even-numbered addresses of a pass (counting from 1) have every field bitwise complemented within its programmed width.
- R9: A field of programmed width w carries only its low w bits: start and end values are masked, stepping wraps modulo 2^w, and all output bits at or above w are 0.
- R10: Column bits 9 to 0 appear on `col_line_o` lines 9 to 0, column bits 12 to 10 appear on lines 13 to 11, and line 10 is always 0.
- R11: `done_o` is 1 only together with `valid_o`, on the last address of the pass. Once that address is accepted, `valid_o` is 0 from the next cycle on.
- R12: While `valid_o` is 1 and `ready_i` is 0, the address outputs and `valid_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load the configuration and begin a pass |
| order_i | input | 2 | Traversal order: 0 fast-X, 1 fast-Y, 2 fast-XY, 3 XZY |
| down_i | input | 1 | 1 = count down, 0 = count up |
| dai_i | input | 1 | Complement alternate addresses |
| row_width_i | input | 5 | Row field width, 1 to 16 |
| col_width_i | input | 4 | Column field width, 1 to 13 |
| bank_width_i | input | 2 | Bank field width, 1 to 3 |
| row_start_i | input | 16 | Row start value |
| row_end_i | input | 16 | Row end value |
| col_start_i | input | 13 | Column start value |
| col_end_i | input | 13 | Column end value |
| bank_start_i | input | 3 | Bank start value |
| bank_end_i | input | 3 | Bank end value |
| ready_i | input | 1 | Command engine accepts the current address |
| valid_o | output | 1 | An address is presented |
| done_o | output | 1 | The presented address is the last of the pass |
| row_o | output | 16 | Row address |
| col_line_o | output | 14 | Column address on the address lines, line 10 unused |
| bank_o | output | 3 | Bank address |

## Verification
The first address is due one clock edge after the edge that samples `start_i`. Each following address is due one edge after the edge that sees `ready_i` high, and `valid_o` falls one edge after the final address is accepted. The bench drives every input on the falling edge and samples on the next falling edge, so each check lands exactly one rising edge after its stimulus. During stall cycles it samples on every falling edge, to confirm that the address has held.

// File: rtl/mt_seq_pkg.sv
package mt_seq_pkg;

  typedef enum logic [1:0] {
    ORD_FAST_X  = 2'd0,
    ORD_FAST_Y  = 2'd1,
    ORD_FAST_XY = 2'd2,
    ORD_XZY     = 2'd3
  } order_e;

  localparam int COL_GAP_LINE = 10;

endpackage

// File: rtl/mt_field_cnt.sv
module mt_field_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] start_i,
  input  logic [W-1:0] end_i,
  input  logic [W-1:0] mask_i,
  input  logic         down_i,
  input  logic         step_i,
  input  logic         wrap_i,
  output logic [W-1:0] val_o,
  output logic         at_end_o
);

  logic [W-1:0] val_q, val_n;
  logic [W-1:0] begin_q, begin_n;
  logic [W-1:0] end_q, end_n;
  logic         en;

  assign at_end_o = (val_q == end_q);
  assign val_o    = val_q;
  assign en       = load_i | step_i;

  always_comb begin
    val_n   = val_q;
    begin_n = begin_q;
    end_n   = end_q;
    if (load_i) begin
      val_n   = start_i & mask_i;
      begin_n = start_i & mask_i;
      end_n   = end_i & mask_i;
    end else if (step_i) begin
      if (at_end_o || wrap_i) val_n = begin_q;
      else if (down_i)        val_n = (val_q - 1'b1) & mask_i;
      else                    val_n = (val_q + 1'b1) & mask_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q   <= '0;
      begin_q <= '0;
      end_q   <= '0;
    end else if (en) begin
      val_q   <= val_n;
      begin_q <= begin_n;
      end_q   <= end_n;
    end
  end

  // R9: no bit above the programmed width is ever set
  p_in_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |-> ((val_q & ~mask_i) == '0));

  // R12: value only moves on a step or a load
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(val_q));

endmodule

// File: rtl/mt_addr_drive.sv
module mt_addr_drive #(
  parameter int ROW_W  = 16,
  parameter int COL_W  = 13,
  parameter int BANK_W = 3,
  parameter int GAP    = 10,
  localparam int LINE_W = (COL_W > GAP) ? COL_W + 1 : COL_W
) (
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_mask_i,
  input  logic [COL_W-1:0]  col_mask_i,
  input  logic [BANK_W-1:0] bank_mask_i,
  input  logic              inv_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [LINE_W-1:0] col_line_o,
  output logic [BANK_W-1:0] bank_o
);

  logic [COL_W-1:0] col_x;

  assign row_o  = row_i  ^ (inv_i ? row_mask_i  : '0);
  assign bank_o = bank_i ^ (inv_i ? bank_mask_i : '0);
  assign col_x  = col_i  ^ (inv_i ? col_mask_i  : '0);

  for (genvar j = 0; j < LINE_W; j++) begin : g_line
    if (j < GAP) begin : g_low
      assign col_line_o[j] = col_x[j];
    end else if (j == GAP) begin : g_gap
      assign col_line_o[j] = 1'b0;
    end else begin : g_high
      assign col_line_o[j] = col_x[j-1];
    end
  end

endmodule

// File: rtl/mt_addr_seq.sv
module mt_addr_seq
  import mt_seq_pkg::*;
#(
  parameter int ROW_W  = 16,
  parameter int COL_W  = 13,
  parameter int BANK_W = 3,
  localparam int RWW    = $clog2(ROW_W + 1),
  localparam int CWW    = $clog2(COL_W + 1),
  localparam int BWW    = $clog2(BANK_W + 1),
  localparam int LINE_W = (COL_W > COL_GAP_LINE) ? COL_W + 1 : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        order_i,
  input  logic              down_i,
  input  logic              dai_i,
  input  logic [RWW-1:0]    row_width_i,
  input  logic [CWW-1:0]    col_width_i,
  input  logic [BWW-1:0]    bank_width_i,
  input  logic [ROW_W-1:0]  row_start_i,
  input  logic [ROW_W-1:0]  row_end_i,
  input  logic [COL_W-1:0]  col_start_i,
  input  logic [COL_W-1:0]  col_end_i,
  input  logic [BANK_W-1:0] bank_start_i,
  input  logic [BANK_W-1:0] bank_end_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic              done_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [LINE_W-1:0] col_line_o,
  output logic [BANK_W-1:0] bank_o
);

  // run state
  logic   run_q, run_n, phase_q, phase_n;
  logic   down_q, down_n, dai_q, dai_n;
  order_e ord_q, ord_n;
  logic [ROW_W-1:0]  rmask_q, rmask_n, rmask_use;
  logic [COL_W-1:0]  cmask_q, cmask_n, cmask_use;
  logic [BANK_W-1:0] bmask_q, bmask_n, bmask_use;

  // counter interface
  logic [ROW_W-1:0]  row_v;
  logic [COL_W-1:0]  col_v;
  logic [BANK_W-1:0] bank_v;
  logic r_end, c_end, b_end, xy_end;
  logic step_r, step_c, step_b, wrap_xy, last, adv;

  // width masks for a new pass
  always_comb begin
    for (int i = 0; i < ROW_W; i++)  rmask_n[i] = (i < int'(row_width_i));
    for (int i = 0; i < COL_W; i++)  cmask_n[i] = (i < int'(col_width_i));
    for (int i = 0; i < BANK_W; i++) bmask_n[i] = (i < int'(bank_width_i));
  end

  assign rmask_use = start_i ? rmask_n : rmask_q;
  assign cmask_use = start_i ? cmask_n : cmask_q;
  assign bmask_use = start_i ? bmask_n : bmask_q;

  // counter chaining per order
  assign xy_end = r_end | c_end;

  always_comb begin
    step_r  = 1'b0;
    step_c  = 1'b0;
    step_b  = 1'b0;
    wrap_xy = 1'b0;
    last    = r_end & c_end & b_end;
    unique case (ord_q)
      ORD_FAST_X: begin
        step_r = 1'b1;
        step_c = r_end;
        step_b = r_end & c_end;
      end
      ORD_FAST_Y: begin
        step_c = 1'b1;
        step_r = c_end;
        step_b = c_end & r_end;
      end
      ORD_FAST_XY: begin
        step_r  = 1'b1;
        step_c  = 1'b1;
        wrap_xy = xy_end;
        step_b  = xy_end;
        last    = xy_end & b_end;
      end
      default: begin
        step_r = 1'b1;
        step_b = r_end;
        step_c = r_end & b_end;
      end
    endcase
  end

  assign adv = run_q & ready_i & ~last;

  // next state
  always_comb begin
    run_n   = run_q;
    phase_n = phase_q;
    down_n  = down_q;
    dai_n   = dai_q;
    ord_n   = ord_q;
    if (start_i) begin
      run_n   = 1'b1;
      phase_n = 1'b0;
      down_n  = down_i;
      dai_n   = dai_i;
      ord_n   = order_e'(order_i);
    end else if (run_q && ready_i) begin
      if (last) run_n = 1'b0;
      else      phase_n = ~phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      phase_q <= 1'b0;
      down_q  <= 1'b0;
      dai_q   <= 1'b0;
      ord_q   <= ORD_FAST_X;
      rmask_q <= '0;
      cmask_q <= '0;
      bmask_q <= '0;
    end else begin
      run_q   <= run_n;
      phase_q <= phase_n;
      down_q  <= down_n;
      dai_q   <= dai_n;
      ord_q   <= ord_n;
      if (start_i) begin
        rmask_q <= rmask_n;
        cmask_q <= cmask_n;
        bmask_q <= bmask_n;
      end
    end
  end

  mt_field_cnt #(.W(ROW_W)) u_row (
    .clk(clk), .rst_n(rst_n), .load_i(start_i),
    .start_i(row_start_i), .end_i(row_end_i), .mask_i(rmask_use),
    .down_i(down_q), .step_i(adv & step_r), .wrap_i(wrap_xy),
    .val_o(row_v), .at_end_o(r_end));

  mt_field_cnt #(.W(COL_W)) u_col (
    .clk(clk), .rst_n(rst_n), .load_i(start_i),
    .start_i(col_start_i), .end_i(col_end_i), .mask_i(cmask_use),
    .down_i(down_q), .step_i(adv & step_c), .wrap_i(wrap_xy),
    .val_o(col_v), .at_end_o(c_end));

  mt_field_cnt #(.W(BANK_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .load_i(start_i),
    .start_i(bank_start_i), .end_i(bank_end_i), .mask_i(bmask_use),
    .down_i(down_q), .step_i(adv & step_b), .wrap_i(1'b0),
    .val_o(bank_v), .at_end_o(b_end));

  mt_addr_drive #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .GAP(COL_GAP_LINE)
  ) u_drive (
    .row_i(row_v), .col_i(col_v), .bank_i(bank_v),
    .row_mask_i(rmask_q), .col_mask_i(cmask_q), .bank_mask_i(bmask_q),
    .inv_i(dai_q & phase_q),
    .row_o(row_o), .col_line_o(col_line_o), .bank_o(bank_o));

  assign valid_o = run_q;
  assign done_o  = run_q & last;

  // R2: a start pulse always yields a presented address next cycle
  p_start_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o);

  // R11: done only with valid
  p_done_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> valid_o);

  // R11: accepted final address ends the pass
  p_pass_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i && done_o && !start_i) |=> !valid_o);

  // R12: stalled address holds
  p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i && !start_i) |=>
      (valid_o && $stable(row_o) && $stable(col_line_o) && $stable(bank_o)));

  // R8: first address after start is never complemented
  p_first_plain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !phase_q);

endmodule

// File: tb/test_mt_addr_seq.sv
module test_mt_addr_seq;

  typedef struct packed {
    logic [1:0]  mode;
    logic        down;
    logic        dai;
    logic [4:0]  rw;
    logic [3:0]  cw;
    logic [1:0]  bw;
    logic [15:0] rs;
    logic [15:0] re;
    logic [12:0] cs;
    logic [12:0] ce;
    logic [2:0]  bs;
    logic [2:0]  be;
    logic [7:0]  cnt;
  } vec_t;

  // mode, down, dai, rw, cw, bw, rs, re, cs, ce, bs, be, expected count
  localparam vec_t VECS [7] = '{
    '{2'd0, 1'b0, 1'b0, 5'd16, 4'd13, 2'd3, 16'd5,  16'd7,  13'd2,    13'd3,    3'd1, 3'd2, 8'd12},
    '{2'd1, 1'b1, 1'b1, 5'd16, 4'd13, 2'd3, 16'd9,  16'd7,  13'd4,    13'd2,    3'd3, 3'd3, 8'd9},
    '{2'd2, 1'b0, 1'b1, 5'd16, 4'd13, 2'd3, 16'd0,  16'd3,  13'd10,   13'd11,   3'd0, 3'd1, 8'd4},
    '{2'd3, 1'b0, 1'b0, 5'd16, 4'd13, 2'd3, 16'd1,  16'd2,  13'd1023, 13'd1024, 3'd0, 3'd2, 8'd12},
    '{2'd0, 1'b0, 1'b1, 5'd3,  4'd2,  2'd1, 16'd6,  16'd1,  13'd3,    13'd3,    3'd1, 3'd0, 8'd8},
    '{2'd0, 1'b1, 1'b1, 5'd4,  4'd13, 2'd3, 16'd1,  16'd14, 13'd0,    13'd0,    3'd0, 3'd0, 8'd4},
    '{2'd2, 1'b1, 1'b0, 5'd16, 4'd13, 2'd3, 16'd20, 16'd18, 13'd5,    13'd0,    3'd2, 3'd1, 8'd6}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  order;
  logic        down, dai, ready;
  logic [4:0]  row_w;
  logic [3:0]  col_w;
  logic [1:0]  bank_w;
  logic [15:0] row_s, row_e;
  logic [12:0] col_s, col_e;
  logic [2:0]  bank_s, bank_e;
  logic        valid, done;
  logic [15:0] row;
  logic [13:0] col_line;
  logic [2:0]  bank;

  int checks = 0;
  int errors = 0;
  int er [512];
  int ec [512];
  int eb [512];

  always #10 clk = ~clk;

  mt_addr_seq i_mt_addr_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .order_i(order),
    .down_i(down), .dai_i(dai), .row_width_i(row_w), .col_width_i(col_w),
    .bank_width_i(bank_w), .row_start_i(row_s), .row_end_i(row_e),
    .col_start_i(col_s), .col_end_i(col_e), .bank_start_i(bank_s),
    .bank_end_i(bank_e), .ready_i(ready), .valid_o(valid), .done_o(done),
    .row_o(row), .col_line_o(col_line), .bank_o(bank));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int seq_len(input int s, input int e, input int m, input bit d);
    return ((d ? s - e : e - s) & m) + 1;
  endfunction

  function automatic int seq_val(input int s, input int k, input int m, input bit d);
    return (d ? s - k : s + k) & m;
  endfunction

  // R10: column bits 12..10 move up to lines 13..11, line 10 stays 0
  function automatic int col_lines(input int c);
    return ((c >> 10) << 11) | (c & 1023);
  endfunction

  function automatic string tag_of(input int vi);
    case (vi)
      0: return "R3";
      1: return "R4";
      2: return "R8";
      3: return "R5";
      4: return "R9";
      5: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic build(input vec_t v, output int n);
    int rm, cm, bm, rs, re, cs, ce, bs, be, nr, nc, nb, nxy;
    rm = (1 << v.rw) - 1;
    cm = (1 << v.cw) - 1;
    bm = (1 << v.bw) - 1;
    rs = int'(v.rs) & rm; re = int'(v.re) & rm;
    cs = int'(v.cs) & cm; ce = int'(v.ce) & cm;
    bs = int'(v.bs) & bm; be = int'(v.be) & bm;
    nr = seq_len(rs, re, rm, v.down);
    nc = seq_len(cs, ce, cm, v.down);
    nb = seq_len(bs, be, bm, v.down);
    nxy = (nr < nc) ? nr : nc;
    n = 0;
    case (v.mode)
      2'd0: for (int b = 0; b < nb; b++) for (int c = 0; c < nc; c++)
              for (int r = 0; r < nr; r++) begin
                er[n] = seq_val(rs, r, rm, v.down); ec[n] = seq_val(cs, c, cm, v.down);
                eb[n] = seq_val(bs, b, bm, v.down); n++;
              end
      2'd1: for (int b = 0; b < nb; b++) for (int r = 0; r < nr; r++)
              for (int c = 0; c < nc; c++) begin
                er[n] = seq_val(rs, r, rm, v.down); ec[n] = seq_val(cs, c, cm, v.down);
                eb[n] = seq_val(bs, b, bm, v.down); n++;
              end
      2'd2: for (int b = 0; b < nb; b++) for (int k = 0; k < nxy; k++) begin
                er[n] = seq_val(rs, k, rm, v.down); ec[n] = seq_val(cs, k, cm, v.down);
                eb[n] = seq_val(bs, b, bm, v.down); n++;
              end
      default: for (int c = 0; c < nc; c++) for (int b = 0; b < nb; b++)
              for (int r = 0; r < nr; r++) begin
                er[n] = seq_val(rs, r, rm, v.down); ec[n] = seq_val(cs, c, cm, v.down);
                eb[n] = seq_val(bs, b, bm, v.down); n++;
              end
    endcase
    if (v.dai) begin
      for (int i = 1; i < n; i += 2) begin
        er[i] = er[i] ^ rm; ec[i] = ec[i] ^ cm; eb[i] = eb[i] ^ bm;
      end
    end
  endtask

  task automatic start_run(input vec_t v);
    order = v.mode; down = v.down; dai = v.dai;
    row_w = v.rw; col_w = v.cw; bank_w = v.bw;
    row_s = v.rs; row_e = v.re; col_s = v.cs; col_e = v.ce;
    bank_s = v.bs; bank_e = v.be;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic check_addr(input string req, input int i);
    chk(req, "row", int'(row), er[i]);
    chk("R10", "col lines", int'(col_line), col_lines(ec[i]));
    chk(req, "bank", int'(bank), eb[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; start = 1'b0; ready = 1'b0; order = '0; down = 1'b0; dai = 1'b0;
    row_w = '0; col_w = '0; bank_w = '0; row_s = '0; row_e = '0;
    col_s = '0; col_e = '0; bank_s = '0; bank_e = '0;
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", int'(valid), 0);
    chk("R1", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "valid after reset", int'(valid), 0);

    // vector table walk
    for (int vi = 0; vi < 7; vi++) begin
      build(VECS[vi], n);
      chk(tag_of(vi), "model length", n, int'(VECS[vi].cnt));
      start_run(VECS[vi]);
      chk("R2", "valid after start", int'(valid), 1);
      check_addr("R2", 0);
      for (int i = 0; i < int'(VECS[vi].cnt); i++) begin
        for (int s = 0; s < ((i % 3 == 1) ? 2 : 0); s++) begin
          check_addr("R12", i);
          chk("R12", "valid in stall", int'(valid), 1);
          @(negedge clk);
        end
        check_addr(tag_of(vi), i);
        chk("R11", "done flag", int'(done), (i == int'(VECS[vi].cnt) - 1) ? 1 : 0);
        chk("R11", "valid", int'(valid), 1);
        ready = 1'b1;
        @(negedge clk);
        ready = 1'b0;
      end
      chk("R11", "valid after last", int'(valid), 0);
      chk("R11", "done after last", int'(done), 0);
    end

    // restart in the middle of a pass
    build(VECS[3], n);
    start_run(VECS[0]);
    ready = 1'b1;
    repeat (3) @(negedge clk);
    ready = 1'b0;
    start_run(VECS[3]);
    chk("R2", "restart valid", int'(valid), 1);
    check_addr("R2", 0);
    chk("R2", "restart done", int'(done), 0);

    // reset in the middle of a pass
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "valid under mid-run reset", int'(valid), 0);
    chk("R1", "done under mid-run reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "valid after mid-run reset", int'(valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule